// File: doc/BRIEF.md
# Multi-Lane Half-Duplex Serial Shifter

This block is the serial engine of a flash-style SPI master. One start pulse moves a buffer of bytes in a single direction, either out to the device or in from it. The data travel over one, two or four data lines, and each transfer picks its own lane width, bit order, clock mode and target device. Transmit bytes come in on a byte-wide valid/ready stream and receive bytes leave on another. The serial clock stops between bytes whenever a stream is not ready, so no data are lost and none are invented.

The serial clock comes from the base clock through an 8-bit divider taken from a 16-bit clock control word. A clock-stable flag tells software when a newly written rate is in effect. The chip select of the addressed device stays low from the first accepted transfer onward. It rises only when a transfer that asked for release finishes, so a command, an address and a data buffer can be sent as separate transfers under one select. Separate output enables per data line stand in for tristate pads.

Top module: `mlspi_engine`

## Requirements
- R1: A start pulse is taken only when all of these hold: the engine is idle, the clock enable (bit 0 of the control word) is set, the stable flag is high, the byte count is nonzero and `cpol` equals `cpha`. Modes 0 and 3 are the only combinations accepted. Any other start leaves `busy` low and leaves the chip selects unchanged.
- R2: The divider is bits 15:8 of the control word. SCK stays high for max(divider,1) base-clock cycles, so its rate is base/(2·max(divider,1)). While idle, SCK rests at the `cpol` level.
- R3: Every write of the control word drives `clk_stable` low in the next cycle. The flag returns high exactly 2·max(divider,1) cycles after the write.
- R4: In a transmit transfer, bytes are taken through the `tx_valid`/`tx_ready` handshake, and each byte goes out as a series of groups. Lane code 0 drives line 0 with one bit per SCK cycle, MSB first. Lane code 1 drives lines 1:0 with two bits per cycle, the higher bit on line 1. Lane code 2 (and the spare code 3) drives lines 3:0 with the high nibble first.
- R5: In a receive transfer, every `dq_oe` bit is low. Bits are sampled on the rising SCK edge: line 1 in single mode, lines 1:0 in dual mode, lines 3:0 in quad mode. Each byte is held on `rx_data` with `rx_valid` high until `rx_ready` is seen.
- R6: With `lsb_first` set, the order of the bits within each byte is reversed on the wire, in both directions.
- R7: While busy, device index 0 drives `cs_n[0]` low and index 1 drives `cs_n[1]` low. Indexes 2 and 3 assert neither select.
- R8: When a transfer ends, the chip selects return high only if `release_cs` was set when that transfer started. Otherwise the select stays low after `done`.
- R9: `done` pulses for one cycle after the final byte completes, and `busy` is low in that cycle.
- R10: During a transmit transfer, `dq_oe` is 4'b0001 for single, 4'b0011 for dual and 4'b1111 for quad. While idle it is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the clock control word |
| ctl_word | input | 16 | Bit 0 is the clock enable; bits 15:8 are the divider |
| clk_stable | output | 1 | High when the programmed rate is in effect |
| start | input | 1 | Start pulse for one transfer |
| byte_cnt | input | 9 | Number of bytes in the transfer |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| lane_mode | input | 2 | 0 single, 1 dual, 2 quad |
| lsb_first | input | 1 | Send or receive each byte LSB first |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase; must equal cpol |
| dev_sel | input | 2 | Device index for chip select |
| release_cs | input | 1 | Raise chip select when this transfer ends |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes the transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| sck | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Data line output enables |
| dq_in | input | 4 | Data line input values |

## Verification
The assertions check, on every cycle, the following properties:
- the data lines are released while receiving;
- a held receive byte stays stable while it waits;
- the transmit data do not move while SCK is high inside a shift;
- exactly one select is low for a valid index while busy;
- a control write lowers the stable flag;
- a rejected start keeps the engine idle.

Only the bench can show the rest:
- the lane-to-bit mapping and the bit order of whole bytes;
- the SCK high time against the divider;
- the exact settling time of the stable flag;
- whether a select is held or released across consecutive transfers.

The bench shows these by sweeping the lane width, direction, bit order and clock mode at two divider settings.

// File: rtl/mlspi_pkg.sv
`timescale 1ns/1ps
package mlspi_pkg;
  typedef enum logic [1:0] {LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2, LANE_XR = 2'd3} lane_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_HAND} st_e;

  // bit mirror of one byte
  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // SCK cycles per byte, minus one
  function automatic logic [2:0] last_unit(input lane_e l);
    case (l)
      LANE_X1: return 3'd7;
      LANE_X2: return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // data lines driven when transmitting
  function automatic logic [3:0] lane_mask(input lane_e l);
    case (l)
      LANE_X1: return 4'b0001;
      LANE_X2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/mlspi_clkgen.sv
`timescale 1ns/1ps
module mlspi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [DIV_W-1:0] ctl_div,
  input  logic             ctl_en,
  input  logic             run,
  output logic             clk_on,
  output logic             stable,
  output logic             half_tick
);
  localparam int HW = DIV_W + 1;
  localparam int SW = DIV_W + 2;

  // half-period length in base cycles: a divider of zero counts as one
  function automatic logic [HW-1:0] half_len(input logic [DIV_W-1:0] d);
    return (d == '0) ? HW'(1) : {1'b0, d};
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic [SW-1:0]    settle_q;
  logic [HW-1:0]    ph_q;
  logic [HW-1:0]    hl;

  assign hl = half_len(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      en_q     <= 1'b0;
      settle_q <= '0;
      ph_q     <= HW'(1);
    end else begin
      if (ctl_wr) begin
        div_q    <= ctl_div;
        en_q     <= ctl_en;
        settle_q <= {half_len(ctl_div), 1'b0};
      end else if (settle_q != '0) begin
        settle_q <= settle_q - SW'(1);
      end
      if (!run || ph_q == hl) ph_q <= HW'(1);
      else                    ph_q <= ph_q + HW'(1);
    end
  end

  assign half_tick = run && (ph_q == hl);
  assign stable    = (settle_q == '0);
  assign clk_on    = en_q;

  a_r3_write_drops_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !stable);
endmodule

// File: rtl/mlspi_shifter.sv
`timescale 1ns/1ps
module mlspi_shifter
  import mlspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift_tx,
  input  logic       sample_rx,
  input  lane_e      lane,
  input  logic       lsb,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [7:0] rx_byte
);
  logic [7:0] sr_q;
  logic [7:0] shifted;

  // one group leaves at the top, the sampled group enters at the bottom
  always_comb begin
    case (lane)
      LANE_X1: begin shifted = {sr_q[6:0], dq_in[1]};   dq_out = {3'b000, sr_q[7]};   end
      LANE_X2: begin shifted = {sr_q[5:0], dq_in[1:0]}; dq_out = {2'b00, sr_q[7:6]}; end
      default: begin shifted = {sr_q[3:0], dq_in[3:0]}; dq_out = sr_q[7:4];           end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sr_q <= '0;
    else if (load)                  sr_q <= lsb ? rev8(load_byte) : load_byte;
    else if (shift_tx || sample_rx) sr_q <= shifted;
  end

  assign rx_byte = lsb ? rev8(sr_q) : sr_q;
endmodule

// File: rtl/mlspi_engine.sv
`timescale 1ns/1ps
module mlspi_engine
  import mlspi_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int DIV_W  = 8,
  parameter int NUM_CS = 2,
  parameter int DEV_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [2*DIV_W-1:0] ctl_word,
  output logic               clk_stable,
  input  logic               start,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic               dir_rx,
  input  logic [1:0]         lane_mode,
  input  logic               lsb_first,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DEV_W-1:0]   dev_sel,
  input  logic               release_cs,
  output logic               busy,
  output logic               done,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic               sck,
  output logic [NUM_CS-1:0]  cs_n,
  output logic [3:0]         dq_out,
  output logic [3:0]         dq_oe,
  input  logic [3:0]         dq_in
);
  st_e              st_q;
  lane_e            lane_q;
  logic             dir_q, lsb_q, cpol_q, rel_q, cs_act_q, phase_q, done_q;
  logic [DEV_W-1:0] dev_q;
  logic [2:0]       unit_q;
  logic [CNT_W-1:0] bytes_q;

  // named events for the assertions and the shifter
  logic run, clk_on, half_tick, start_ok;
  logic ev_rise, ev_fall, ev_byte_end, ev_finish;
  logic unused_ctl;

  assign unused_ctl = ^ctl_word[DIV_W-1:1];
  assign run        = (st_q == ST_SHIFT);

  mlspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_div   (ctl_word[2*DIV_W-1:DIV_W]),
    .ctl_en    (ctl_word[0]),
    .run       (run),
    .clk_on    (clk_on),
    .stable    (clk_stable),
    .half_tick (half_tick)
  );

  assign start_ok    = (st_q == ST_IDLE) && start && clk_on && clk_stable &&
                       (byte_cnt != '0) && (cpol == cpha);
  assign ev_rise     = run && half_tick && !phase_q;
  assign ev_fall     = run && half_tick && phase_q;
  assign ev_byte_end = ev_fall && (unit_q == '0);
  assign ev_finish   = (ev_byte_end && !dir_q && bytes_q == CNT_W'(1)) ||
                       (st_q == ST_HAND && rx_ready && bytes_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lane_q   <= LANE_X1;
      dir_q    <= 1'b0;
      lsb_q    <= 1'b0;
      cpol_q   <= 1'b0;
      rel_q    <= 1'b0;
      cs_act_q <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      dev_q    <= '0;
      unit_q   <= '0;
      bytes_q  <= '0;
    end else begin
      done_q <= ev_finish;
      if (ev_finish && rel_q) cs_act_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          cpol_q <= cpol;
          if (start_ok) begin
            dir_q    <= dir_rx;
            lane_q   <= lane_e'(lane_mode);
            lsb_q    <= lsb_first;
            dev_q    <= dev_sel;
            rel_q    <= release_cs;
            bytes_q  <= byte_cnt;
            cs_act_q <= 1'b1;
            unit_q   <= last_unit(lane_e'(lane_mode));
            phase_q  <= 1'b0;
            st_q     <= dir_rx ? ST_SHIFT : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (tx_valid) begin
            st_q    <= ST_SHIFT;
            unit_q  <= last_unit(lane_q);
            phase_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (half_tick) begin
            phase_q <= !phase_q;
            if (phase_q) begin
              if (unit_q != '0) begin
                unit_q <= unit_q - 3'd1;
              end else begin
                bytes_q <= bytes_q - CNT_W'(1);
                if (dir_q)                      st_q <= ST_HAND;
                else if (bytes_q == CNT_W'(1))  st_q <= ST_IDLE;
                else                            st_q <= ST_LOAD;
              end
            end
          end
        end
        default: begin
          if (rx_ready) begin
            if (bytes_q == '0) begin
              st_q <= ST_IDLE;
            end else begin
              st_q    <= ST_SHIFT;
              unit_q  <= last_unit(lane_q);
              phase_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  mlspi_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (st_q == ST_LOAD && tx_valid),
    .load_byte (tx_data),
    .shift_tx  (ev_fall && unit_q != '0 && !dir_q),
    .sample_rx (ev_rise && dir_q),
    .lane      (lane_q),
    .lsb       (lsb_q),
    .dq_in     (dq_in),
    .dq_out    (dq_out),
    .rx_byte   (rx_data)
  );

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign tx_ready = (st_q == ST_LOAD);
  assign rx_valid = (st_q == ST_HAND);
  assign sck      = run ? phase_q : cpol_q;
  assign dq_oe    = (busy && !dir_q) ? lane_mask(lane_q) : 4'b0000;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_act_q && (dev_q == DEV_W'(g)));
  end

  a_r1_reject_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && !start_ok) |=> !busy);
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == $past(cpol)));
  a_r4_data_still_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && sck && $past(sck)) |-> $stable(dq_out));
  a_r5_rx_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_q) |-> (dq_oe == 4'b0000));
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(dev_q) < NUM_CS) |-> ($countones(~cs_n) == 1));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/mlspi_engine_tb.sv
`timescale 1ns/1ps
module mlspi_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ctl_wr = 1'b0, start = 1'b0, dir_rx = 1'b0, lsb_first = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, release_cs = 1'b0, rx_ready = 1'b0;
  logic [15:0] ctl_word = '0;
  logic [8:0]  byte_cnt = '0;
  logic [1:0]  lane_mode = '0, dev_sel = '0;
  logic        clk_stable, busy, done, tx_ready, tx_valid, rx_valid, sck;
  logic [7:0]  tx_data, rx_data;
  logic [1:0]  cs_n;
  logic [3:0]  dq_out, dq_oe, dq_in;

  mlspi_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word), .clk_stable(clk_stable),
    .start(start), .byte_cnt(byte_cnt), .dir_rx(dir_rx), .lane_mode(lane_mode),
    .lsb_first(lsb_first), .cpol(cpol), .cpha(cpha), .dev_sel(dev_sel), .release_cs(release_cs),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .sck(sck), .cs_n(cs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int errs = 0, checks = 0, cyc = 0;
  logic [7:0] tx_arr [0:7];
  logic [7:0] rx_arr [0:7];
  int  cur_w = 1, n = 0, tx_idx = 0, rx_idx = 0, cap_idx = 0, ucnt = 0, rx_unit = 0, E = 1;
  bit  cur_rx = 0, cur_lsb = 0, in_xfer = 0, hi_armed = 0, wid_done = 0, first_seen = 0;
  logic [7:0] acc = '0;
  logic [3:0] exp_oe;
  logic [1:0] exp_cs;
  realtime t_rise;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] b);
    return {<<{b}};
  endfunction

  // wire group number u of byte b, for w lines
  function automatic logic [3:0] grp(input logic [7:0] b, input bit lsb, input int w, input int u);
    int r;
    r = lsb ? int'(mirror(b)) : int'(b);
    return 4'((r >> (8 - w * (u + 1))) & ((1 << w) - 1));
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rx_ready <= (cyc % 3) != 0;
  end

  // transmit source
  assign tx_data  = tx_arr[tx_idx % 8];
  assign tx_valid = in_xfer && !cur_rx && (tx_idx < n);
  always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;

  // receive device model: lines outside the lane carry junk
  always @* begin
    logic [3:0] c;
    c = grp(rx_arr[(rx_unit / (8 / cur_w)) % 8], cur_lsb, cur_w, rx_unit % (8 / cur_w));
    case (cur_w)
      1:       dq_in = {2'b10, c[0], 1'b1};
      2:       dq_in = {2'b10, c[1:0]};
      default: dq_in = c;
    endcase
  end

  always @(posedge clk) if (rx_valid && rx_ready) begin
    chk(rx_data == rx_arr[rx_idx % 8], cur_lsb ? "R6 rx byte" : "R5 rx byte", rx_data, rx_arr[rx_idx % 8]);
    rx_idx <= rx_idx + 1;
  end

  always @(posedge sck) if (in_xfer) begin
    if (!first_seen) begin
      first_seen = 1;
      chk(dq_oe == exp_oe, cur_rx ? "R5 oe" : "R10 oe", dq_oe, exp_oe);
      chk(cs_n == exp_cs, "R7 select", cs_n, exp_cs);
    end
    if (!wid_done) begin hi_armed = 1; t_rise = $realtime; end
    if (cur_rx) rx_unit = rx_unit + 1;
    else begin
      case (cur_w)
        1:       acc = {acc[6:0], dq_out[0]};
        2:       acc = {acc[5:0], dq_out[1:0]};
        default: acc = {acc[3:0], dq_out[3:0]};
      endcase
      ucnt++;
      if (ucnt == 8 / cur_w) begin
        chk((cur_lsb ? mirror(acc) : acc) == tx_arr[cap_idx % 8], cur_lsb ? "R6 tx byte" : "R4 tx byte",
            cur_lsb ? mirror(acc) : acc, tx_arr[cap_idx % 8]);
        cap_idx++;
        ucnt = 0;
      end
    end
  end

  always @(negedge sck) if (in_xfer && hi_armed) begin
    chk((($realtime - t_rise) > E * 5.0 - 0.1) && (($realtime - t_rise) < E * 5.0 + 0.1),
        "R2 sck high", int'($realtime - t_rise), E * 5);
    hi_armed = 0;
    wid_done = 1;
  end

  task automatic write_ctl(input bit en, input int div);
    int e;
    e = (div == 0) ? 1 : div;
    @(negedge clk);
    ctl_word = {8'(div), 7'h55, en};
    ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
    chk(clk_stable == 0, "R3 drop", clk_stable, 0);
    repeat (2 * e - 1) @(negedge clk);
    chk(clk_stable == 0, "R3 still low", clk_stable, 0);
    @(negedge clk);
    chk(clk_stable == 1, "R3 back high", clk_stable, 1);
    E = e;
  endtask

  task automatic try_reject(input bit pol, input bit pha, input int cnt, input string why);
    @(negedge clk);
    cpol = pol; cpha = pha; byte_cnt = 9'(cnt); dev_sel = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 0, why, busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_n == 2'b11, why, {busy, cs_n}, 3);
  endtask

  task automatic run_xfer(input int lane, input bit rx, input bit lsb, input bit m3,
                          input int dev, input bit rel, input int nb);
    logic [1:0] after;
    @(negedge clk);
    cpol = m3; cpha = m3;
    repeat (2) @(negedge clk);
    chk(sck == m3, "R2 idle level", sck, m3);
    for (int i = 0; i < nb; i++) begin
      tx_arr[i] = 8'(i * 53 + lane * 17 + 8'h3C) ^ {7'h0, lsb};
      rx_arr[i] = 8'(i * 71 + lane * 29 + 8'hC5) ^ {m3, 7'h0};
    end
    cur_w = (lane == 0) ? 1 : (lane == 1) ? 2 : 4;
    cur_rx = rx; cur_lsb = lsb; n = nb;
    tx_idx = 0; rx_idx = 0; cap_idx = 0; acc = 0; ucnt = 0; rx_unit = 0;
    hi_armed = 0; wid_done = 0; first_seen = 0;
    exp_oe = rx ? 4'b0000 : (lane == 0) ? 4'b0001 : (lane == 1) ? 4'b0011 : 4'b1111;
    exp_cs = (dev < 2) ? ~(2'b01 << dev) : 2'b11;
    in_xfer = 1;
    lane_mode = 2'(lane); dir_rx = rx; lsb_first = lsb; dev_sel = 2'(dev);
    release_cs = rel; byte_cnt = 9'(nb); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 accept", busy, 1);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1 && busy == 0, "R9 done", {done, busy}, 2);
    chk((rx ? rx_idx : cap_idx) == nb, rx ? "R5 count" : "R4 count", rx ? rx_idx : cap_idx, nb);
    after = rel ? 2'b11 : exp_cs;
    chk(cs_n == after, "R8 select at end", cs_n, after);
    in_xfer = 0;
    repeat (3) @(negedge clk);
    chk(cs_n == after && dq_oe == 4'b0000, "R8 select held / R10 idle oe", {cs_n, dq_oe}, {after, 4'b0000});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cs_n == 2'b11 && sck == 0, "R9 reset idle", {busy, cs_n, sck}, 6);
    chk(dq_oe == 4'b0000 && tx_ready == 0 && rx_valid == 0, "R10 reset oe", dq_oe, 0);
    chk(clk_stable == 1, "R3 reset stable", clk_stable, 1);
    try_reject(0, 0, 2, "R1 clock off");
    write_ctl(1, 0);
    try_reject(1, 0, 2, "R1 mode 2");
    try_reject(0, 1, 2, "R1 mode 1");
    try_reject(0, 0, 0, "R1 zero count");
    @(negedge clk);
    ctl_word = {8'd5, 8'h01}; ctl_wr = 1; cpol = 0; cpha = 0; byte_cnt = 2;
    @(negedge clk);
    ctl_wr = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 0, "R1 not stable", busy, 0);
    foreach (E_list[d]) begin
      write_ctl(1, E_list[d]);
      for (int idx = 0; idx < 24; idx++) begin
        run_xfer(idx % 3, (idx / 3) % 2, (idx / 6) % 2, (idx / 12) % 2,
                 (idx % 5 == 4) ? 2 : idx % 2, idx[0], 3);
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  int E_list [2] = '{0, 3};

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule